// File: doc/BRIEF.md
# Relative Jump Decoder and Target Calculator

This block looks at the first bytes of a fetched instruction and recognises the four relative jump encodings: short and long conditional jumps, and short and long unconditional jumps. For a recognised jump it reports the instruction length and the 4-bit condition code. It evaluates that condition against the current status flags and says whether the jump is taken. It also computes the next instruction address. That address is the branch target when the jump is taken, and the fall-through address when it is not.

A caller presents a six-byte window, the current instruction pointer and the flags, and raises `in_valid` for one cycle. The decoded result is registered and shows up on the outputs at the next clock edge. A two-state controller tracks whether the outputs hold a fresh result.

The controller has two states, `ST_IDLE` and `ST_EMIT`, and these transitions:
- `ST_IDLE` goes to `ST_EMIT` when `in_valid` is sampled high.
- `ST_EMIT` stays in `ST_EMIT` when `in_valid` is high again.
- `ST_EMIT` returns to `ST_IDLE` when `in_valid` is low.

Top module: `rel_jump_decoder`

## Requirements
- R1: After reset, `out_valid`, `taken`, `illegal`, `ilen`, `cond` and `target` are all zero.
- R2: An accepted window (`in_valid` high at a rising edge) produces `out_valid` high in the following cycle. A cycle with `in_valid` low produces `out_valid` low in the following cycle and leaves every other output unchanged.
- R3: Window byte 0 is the first instruction byte. When its upper nibble is 7, the form is a short conditional jump. It has length 2, the condition is the low nibble of byte 0, and the displacement is byte 1 read as a signed 8-bit value.
- R4: When byte 0 is 0x0F and the upper nibble of byte 1 is 8, the form is a long conditional jump. It has length 6, the condition is the low nibble of byte 1, and the displacement is the signed 32-bit value in bytes 2 to 5, least significant byte first.
- R5: Byte 0 = 0xEB is a short unconditional jump: length 2, signed 8-bit displacement in byte 1. Byte 0 = 0xE9 is a long unconditional jump: length 5, signed 32-bit little-endian displacement in bytes 1 to 4. Both forms always set `taken`, and both report `cond` = 0.
- R6: The condition codes map as follows. The `flags` bit positions are CF=bit 0, PF=bit 1, ZF=bit 2, SF=bit 3 and OF=bit 4.

  | Code | Taken when |
  |---|---|
  | 0 | OF |
  | 1 | not OF |
  | 2 | CF |
  | 3 | not CF |
  | 4 | ZF |
  | 5 | not ZF |
  | 6 | CF or ZF |
  | 7 | neither CF nor ZF |
  | 8 | SF |
  | 9 | not SF |
  | A | PF |
  | B | not PF |
  | C | SF differs from OF |
  | D | SF equals OF |
  | E | ZF, or SF differs from OF |
  | F | not ZF, and SF equals OF |

- R7: `target` is `ip` + length + displacement when taken, and `ip` + length when not taken. The arithmetic wraps modulo 2^32.
- R8: Any other byte pattern sets `illegal` and reports `taken` = 0, `ilen` = 0, `cond` = 0 and `target` = `ip`.
- R9: Window bytes beyond the decoded instruction's length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window, ip and flags are valid this cycle |
| win | input | 48 | Instruction bytes, byte 0 in bits 7:0 |
| ip | input | 32 | Address of the first window byte |
| flags | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| out_valid | output | 1 | Outputs hold a result accepted in the previous cycle |
| ilen | output | 3 | Instruction length in bytes, 0 when illegal |
| taken | output | 1 | Jump is taken |
| target | output | 32 | Next instruction address |
| cond | output | 4 | Condition code of a conditional form, else 0 |
| illegal | output | 1 | Window is not one of the four jump forms |

## Verification
Every result of this block is due exactly one rising edge after the window is accepted. This applies to length, condition, taken, target and the illegal flag alike, since all of them pass through one register stage. The bench drives each window at a falling edge and compares all outputs at the next falling edge, so exactly one rising edge lies between stimulus and sample. Hold behaviour is checked the same way: the bench drives a cycle with `in_valid` low and changed inputs, then compares at the next falling edge.

// File: rtl/rjd_pkg.sv
package rjd_pkg;

    typedef enum logic [2:0] {
        FORM_BAD,
        FORM_JCC_S,
        FORM_JCC_L,
        FORM_JMP_S,
        FORM_JMP_L
    } jform_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } rjd_state_e;

    localparam logic [7:0] OPC_JMP_SHORT = 8'hEB;
    localparam logic [7:0] OPC_JMP_LONG  = 8'hE9;
    localparam logic [7:0] OPC_ESCAPE    = 8'h0F;
    localparam logic [3:0] HI_JCC_SHORT  = 4'h7;
    localparam logic [3:0] HI_JCC_LONG   = 4'h8;

    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_ZF = 2;
    localparam int FLG_SF = 3;
    localparam int FLG_OF = 4;
    localparam int FLG_W  = 5;

endpackage

// File: rtl/rjd_form_decode.sv
module rjd_form_decode
    import rjd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DISP_BYTES = 4,
    localparam int WIN_BYTES = DISP_BYTES + 2,
    localparam int LEN_W     = $clog2(WIN_BYTES + 1),
    localparam int DW        = 8 * DISP_BYTES
) (
    input  logic [8*WIN_BYTES-1:0] win,
    output jform_e                 form,
    output logic [LEN_W-1:0]       len,
    output logic [3:0]             cc,
    output logic [ADDR_W-1:0]      disp
);

    localparam logic [LEN_W-1:0] LEN_SHORT   = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_JMP_LNG = LEN_W'(1 + DISP_BYTES);
    localparam logic [LEN_W-1:0] LEN_JCC_LNG = LEN_W'(2 + DISP_BYTES);

    logic [7:0]    byte_q [WIN_BYTES];
    logic [DW-1:0] disp_at1;
    logic [DW-1:0] disp_at2;

    genvar gi;
    generate
        for (gi = 0; gi < WIN_BYTES; gi++) begin : g_bytes
            assign byte_q[gi] = win[8*gi +: 8];
        end
        for (gi = 0; gi < DISP_BYTES; gi++) begin : g_disp
            assign disp_at1[8*gi +: 8] = byte_q[1 + gi];
            assign disp_at2[8*gi +: 8] = byte_q[2 + gi];
        end
    endgenerate

    always_comb begin
        form = FORM_BAD;
        if (byte_q[0][7:4] == HI_JCC_SHORT) begin
            form = FORM_JCC_S;
        end else if (byte_q[0] == OPC_JMP_SHORT) begin
            form = FORM_JMP_S;
        end else if (byte_q[0] == OPC_JMP_LONG) begin
            form = FORM_JMP_L;
        end else if (byte_q[0] == OPC_ESCAPE && byte_q[1][7:4] == HI_JCC_LONG) begin
            form = FORM_JCC_L;
        end
    end

    always_comb begin
        len  = '0;
        cc   = '0;
        disp = '0;
        unique case (form)
            FORM_JCC_S: begin
                len  = LEN_SHORT;
                cc   = byte_q[0][3:0];
                disp = ADDR_W'($signed(byte_q[1]));
            end
            FORM_JMP_S: begin
                len  = LEN_SHORT;
                disp = ADDR_W'($signed(byte_q[1]));
            end
            FORM_JMP_L: begin
                len  = LEN_JMP_LNG;
                disp = ADDR_W'($signed(disp_at1));
            end
            FORM_JCC_L: begin
                len  = LEN_JCC_LNG;
                cc   = byte_q[1][3:0];
                disp = ADDR_W'($signed(disp_at2));
            end
            default: begin
                len  = '0;
            end
        endcase
    end

endmodule

// File: rtl/rjd_cond_eval.sv
module rjd_cond_eval
    import rjd_pkg::*;
(
    input  logic [3:0]       cc,
    input  logic [FLG_W-1:0] flags,
    output logic             met
);

    logic base;
    logic sgn_ne_ovf;

    assign sgn_ne_ovf = flags[FLG_SF] ^ flags[FLG_OF];

    always_comb begin
        unique case (cc[3:1])
            3'd0: base = flags[FLG_OF];
            3'd1: base = flags[FLG_CF];
            3'd2: base = flags[FLG_ZF];
            3'd3: base = flags[FLG_CF] | flags[FLG_ZF];
            3'd4: base = flags[FLG_SF];
            3'd5: base = flags[FLG_PF];
            3'd6: base = sgn_ne_ovf;
            3'd7: base = flags[FLG_ZF] | sgn_ne_ovf;
            default: base = 1'b0;
        endcase
    end

    assign met = base ^ cc[0];

endmodule

// File: rtl/rjd_target_calc.sv
module rjd_target_calc #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic [ADDR_W-1:0] ip,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] disp,
    input  logic              take,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] next_ip;

    assign next_ip = ip + ADDR_W'(len);
    assign target  = take ? (next_ip + disp) : next_ip;

endmodule

// File: rtl/rel_jump_decoder.sv
module rel_jump_decoder
    import rjd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DISP_BYTES = 4,
    localparam int WIN_BYTES = DISP_BYTES + 2,
    localparam int LEN_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [8*WIN_BYTES-1:0] win,
    input  logic [ADDR_W-1:0]      ip,
    input  logic [FLG_W-1:0]       flags,
    output logic                   out_valid,
    output logic [LEN_W-1:0]       ilen,
    output logic                   taken,
    output logic [ADDR_W-1:0]      target,
    output logic [3:0]             cond,
    output logic                   illegal
);

    jform_e            form;
    logic [LEN_W-1:0]  dec_len;
    logic [3:0]        dec_cc;
    logic [ADDR_W-1:0] dec_disp;
    logic              cc_met;
    logic              is_cond;
    logic              is_legal;
    logic              take_c;
    logic [ADDR_W-1:0] tgt_c;

    rjd_state_e state_q;
    rjd_state_e state_d;

    rjd_form_decode #(
        .ADDR_W     (ADDR_W),
        .DISP_BYTES (DISP_BYTES)
    ) u_decode (
        .win  (win),
        .form (form),
        .len  (dec_len),
        .cc   (dec_cc),
        .disp (dec_disp)
    );

    rjd_cond_eval u_cond (
        .cc    (dec_cc),
        .flags (flags),
        .met   (cc_met)
    );

    assign is_legal = (form != FORM_BAD);
    assign is_cond  = (form == FORM_JCC_S) || (form == FORM_JCC_L);
    assign take_c   = is_legal && (!is_cond || cc_met);

    rjd_target_calc #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_target (
        .ip     (ip),
        .len    (dec_len),
        .disp   (dec_disp),
        .take   (take_c),
        .target (tgt_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilen    <= '0;
            taken   <= 1'b0;
            target  <= '0;
            cond    <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            ilen    <= dec_len;
            taken   <= take_c;
            target  <= tgt_c;
            cond    <= dec_cc;
            illegal <= !is_legal;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/rel_jump_decoder_chk.sv
module rel_jump_decoder_chk #(
    parameter int ADDR_W     = 32,
    parameter int DISP_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       op_lo,
    input logic [ADDR_W-1:0] ip,
    input logic              out_valid,
    input logic [LEN_W-1:0]  ilen,
    input logic              taken,
    input logic [ADDR_W-1:0] target,
    input logic [3:0]        cond,
    input logic              illegal
);

    localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] L_JMPL  = LEN_W'(1 + DISP_BYTES);
    localparam logic [LEN_W-1:0] L_JCCL  = LEN_W'(2 + DISP_BYTES);

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(target) && $stable(ilen) && $stable(taken)
                       && $stable(cond) && $stable(illegal)));

    assert_short_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_lo[7:4]) == 4'h7)
        |-> (ilen == L_SHORT && cond == $past(op_lo[3:0]) && !illegal));

    assert_long_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_lo[7:0]) == 8'h0F && $past(op_lo[15:12]) == 4'h8)
        |-> (ilen == L_JCCL && cond == $past(op_lo[11:8]) && !illegal));

    assert_uncond_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_lo[7:0]) == 8'hEB || $past(op_lo[7:0]) == 8'hE9))
        |-> (taken && cond == 4'h0 && (ilen == L_SHORT || ilen == L_JMPL)));

    assert_fall_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken && !illegal)
        |-> (target == $past(ip) + ADDR_W'(ilen)));

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal)
        |-> (!taken && ilen == '0 && cond == 4'h0 && target == $past(ip)));

endmodule

bind rel_jump_decoder rel_jump_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .DISP_BYTES (DISP_BYTES),
    .LEN_W      (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_lo     (win[15:0]),
    .ip        (ip),
    .out_valid (out_valid),
    .ilen      (ilen),
    .taken     (taken),
    .target    (target),
    .cond      (cond),
    .illegal   (illegal)
);

// File: tb/rel_jump_decoder_bench.sv
`timescale 1ns/1ps
module rel_jump_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] win = '0;
    logic [31:0] ip = '0;
    logic [4:0]  flags = '0;
    logic        out_valid;
    logic [2:0]  ilen;
    logic        taken;
    logic [31:0] target;
    logic [3:0]  cond;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rel_jump_decoder u_rel_jump_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .win       (win),
        .ip        (ip),
        .flags     (flags),
        .out_valid (out_valid),
        .ilen      (ilen),
        .taken     (taken),
        .target    (target),
        .cond      (cond),
        .illegal   (illegal)
    );

    // flags: CF=0 PF=1 ZF=2 SF=3 OF=4
    function automatic bit cond_true(input logic [3:0] c, input logic [4:0] f);
        bit cf = f[0], pf = f[1], zf = f[2], sf = f[3], of = f[4];
        case (c)
            4'h0: return of;
            4'h1: return !of;
            4'h2: return cf;
            4'h3: return !cf;
            4'h4: return zf;
            4'h5: return !zf;
            4'h6: return cf || zf;
            4'h7: return !cf && !zf;
            4'h8: return sf;
            4'h9: return !sf;
            4'hA: return pf;
            4'hB: return !pf;
            4'hC: return sf != of;
            4'hD: return sf == of;
            4'hE: return zf || (sf != of);
            default: return !zf && (sf == of);
        endcase
    endfunction

    // packed expectation: {illegal, ilen, cond, taken, target}
    function automatic logic [40:0] model(input logic [47:0] w, input logic [31:0] pc,
                                          input logic [4:0] f);
        logic [7:0]  b0 = w[7:0];
        logic [7:0]  b1 = w[15:8];
        logic [31:0] d  = 0;
        logic [2:0]  n  = 0;
        logic [3:0]  c  = 0;
        bit          t  = 0;
        bit          bad = 0;
        if (b0[7:4] == 4'h7) begin
            n = 2; c = b0[3:0]; d = {{24{b1[7]}}, b1}; t = cond_true(c, f);
        end else if (b0 == 8'hEB) begin
            n = 2; d = {{24{b1[7]}}, b1}; t = 1;
        end else if (b0 == 8'hE9) begin
            n = 5; d = w[39:8]; t = 1;
        end else if (b0 == 8'h0F && b1[7:4] == 4'h8) begin
            n = 6; c = b1[3:0]; d = w[47:16]; t = cond_true(c, f);
        end else begin
            bad = 1;
        end
        return {bad, n, c, t, pc + 32'(n) + (t ? d : 32'd0)};
    endfunction

    task automatic compare(input string req, input logic [40:0] exp);
        logic [40:0] got = {illegal, ilen, cond, taken, target};
        checks++;
        if (!out_valid || got !== exp) begin
            errors++;
            $display("FAIL %s: got v=%0b ill=%0b len=%0d cc=%h tk=%0b tgt=%h exp v=1 ill=%0b len=%0d cc=%h tk=%0b tgt=%h",
                     req, out_valid, got[40], got[39:37], got[36:33], got[32], got[31:0],
                     exp[40], exp[39:37], exp[36:33], exp[32], exp[31:0]);
        end
    endtask

    // drive at a falling edge, compare one rising edge later
    task automatic apply(input string req, input logic [47:0] w, input logic [31:0] pc,
                         input logic [4:0] f);
        @(negedge clk);
        win = w; ip = pc; flags = f; in_valid = 1'b1;
        @(negedge clk);
        compare(req, model(w, pc, f));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got running expected finished");
        finish_run();
    end

    initial begin
        logic [40:0] last;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if ({out_valid, illegal, ilen, cond, taken, target} !== '0) begin
            errors++;
            $display("FAIL R1: got v=%0b ill=%0b len=%0d cc=%h tk=%0b tgt=%h expected all zero",
                     out_valid, illegal, ilen, cond, taken, target);
        end
        rst_n = 1'b1;

        // R3 R5 R8: every first byte
        for (int i = 0; i < 256; i++)
            apply("R3/R5/R8 byte0 sweep", {8'hF8, 8'h56, 8'h34, 8'h12, 8'h85, 8'(i)},
                  32'h1000_0000 + 32'(i * 37), 5'(i));

        // R4 R8: every second byte after the escape
        for (int j = 0; j < 256; j++)
            apply("R4/R8 byte1 sweep", {8'hF0, 8'h00, 8'h10, 8'(j) ^ 8'h5A, 8'(j), 8'h0F},
                  32'h0040_0000 - 32'(j * 101), 5'(j * 7));

        // R6: all conditions against all flag patterns, both conditional forms
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f++) begin
                apply("R6 short cond", {8'h11, 8'h22, 8'h33, 8'h44, 8'h80, 4'h7, 4'(c)},
                      32'h0000_2000 + 32'(f), 5'(f));
                apply("R6 long cond", {8'h7F, 8'hFF, 8'hFF, 8'hFF, 4'h8, 4'(c), 8'h0F},
                      32'h8000_0000 + 32'(c), 5'(f));
            end

        // R7 boundaries and wrap
        apply("R7 short max fwd wrap", {32'h0, 8'h7F, 8'hEB}, 32'hFFFF_FFFE, 5'd0);
        apply("R7 short max back", {32'h0, 8'h80, 8'hEB}, 32'h0000_0000, 5'd0);
        apply("R7 long most negative", {8'h00, 32'h8000_0000, 8'hE9}, 32'h0000_0010, 5'd0);
        apply("R7 long zero disp", {8'h00, 32'h0, 8'hE9}, 32'hFFFF_FFFC, 5'd0);
        apply("R7 not taken wrap", {8'h00, 8'h00, 8'h00, 8'h10, 8'h84, 8'h0F}, 32'hFFFF_FFFD, 5'd0);
        apply("R7 taken long cond", {32'hFFFF_FFFA, 8'h84, 8'h0F}, 32'h0000_0100, 5'b00100);

        // R9: trailing bytes do not matter
        apply("R9 short trailing A", {32'h0000_0000, 8'h10, 8'hEB}, 32'h0000_5000, 5'd0);
        apply("R9 short trailing B", {32'hDEAD_BEEF, 8'h10, 8'hEB}, 32'h0000_5000, 5'd0);
        apply("R9 long jmp trailing", {8'hC3, 32'h0000_0100, 8'hE9}, 32'h0000_5000, 5'd0);

        // R2: idle cycle holds outputs and drops out_valid
        last = {illegal, ilen, cond, taken, target};
        @(negedge clk);
        in_valid = 1'b0; win = {40'h0, 8'h74}; ip = 32'h1234_5678; flags = 5'h1F;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || {illegal, ilen, cond, taken, target} !== last) begin
            errors++;
            $display("FAIL R2 hold: got v=%0b res=%h expected v=0 res=%h",
                     out_valid, {illegal, ilen, cond, taken, target}, last);
        end
        apply("R2 resume after idle", {32'h0, 8'hFE, 8'h75}, 32'h0000_0300, 5'd0);
        finish_run();
    end

endmodule